// File: doc/BRIEF.md
# Center-Aligned Dual-Compare PWM Generator

This block produces two symmetric pulse-width-modulated outputs from a single triangle time base. The counter climbs from zero to a programmable period and then falls back to zero, one step per clock, so a full PWM cycle lasts twice the period value. Each output owns a compare value and two programmable actions. One action is applied when the counter meets the compare value while rising, the other when it meets it while falling. Setting on the rising match and clearing on the falling match gives a pulse centred on the counter peak.

The period and both compare values are written into shadow copies. The running copies take the shadow values only at the zero point of the counter, so a new duty or period takes effect on a cycle boundary and never cuts a pulse in half. A clear strobe forces the counter back to zero and restarts the count upward. The counter value and its direction are available as outputs, so neighbouring logic can align to the triangle.

Top module: `updown_pwm`

## Requirements
- R1: With an active period P > 0, the counter steps 0, 1, ..., P, P-1, ..., 1 and then returns to 0, one step per clock, so the cycle lasts 2*P clocks. It never exceeds the active period. With an active period of 0 it holds at 0.
- R2: `dir_down` is 0 while the counter rises. It becomes 1 on the clock after the counter holds the active period. It returns to 0 on the clock after the counter holds 0. A match at either turning point uses the direction in effect before the turn.
- R3: With rising action set and falling action clear, and a compare value C where 1 <= C < P, the output is high for exactly 2*(P-C) clocks of each cycle. It rises one clock after the rising match and falls one clock after the falling match. With C == P the output is set at the peak and is never cleared.
- R4: A compare write lands in its shadow. The active compare changes only at a clock where the counter is 0. A write in the middle of a cycle leaves the current cycle's pulse unchanged and applies from the next cycle.
- R5: A period write lands in its shadow. The active period changes only at a clock where the counter is 0, so the cycle in progress completes with the old period.
- R6: When `ctr_clr` is high at a clock edge, the counter is 0 and `dir_down` is 0 after that edge. Counting resumes upward from there.
- R7: Each action field uses 2'b00 for no change, 2'b01 for drive low, 2'b10 for drive high and 2'b11 for invert. An output changes only at a clock that follows a compare event on its own channel.
- R8: A compare value greater than the active period never matches, so the output produces no events. A compare of 0 matches only at the zero point, where the direction is normally falling. Under set-rise/clear-fall both cases leave the output low.
- R9: Synchronous reset clears the counter, sets the direction to rising, drives both outputs low and loads zero into the shadow and active period and compare registers. After reset, and before any period write, the counter stays at 0.
- R10: The two channels are independent. Each one uses only its own compare value and action fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock; the counter moves one step per edge |
| rst | input | 1 | Synchronous reset, active high |
| ctr_clr | input | 1 | Forces the counter to zero and the direction to rising |
| prd_wr | input | 1 | Write strobe for the period shadow |
| prd_wdata | input | W | Period value to store |
| cmpa_wr | input | 1 | Write strobe for the channel A compare shadow |
| cmpa_wdata | input | W | Channel A compare value |
| cmpb_wr | input | 1 | Write strobe for the channel B compare shadow |
| cmpb_wdata | input | W | Channel B compare value |
| act_a_up | input | 2 | Channel A action on a rising match |
| act_a_dn | input | 2 | Channel A action on a falling match |
| act_b_up | input | 2 | Channel B action on a rising match |
| act_b_dn | input | 2 | Channel B action on a falling match |
| ctr | output | W | Current time-base count |
| dir_down | output | 1 | 1 while the counter is falling |
| out_a | output | 1 | PWM output A |
| out_b | output | 1 | PWM output B |

## Verification
The assertions check the following on every clock:
- The count stays within the active period and climbs by one between the turning points.
- The direction flips exactly at the peak and at zero.
- The active period and compare values move only at zero.
- An output stays still on any clock without an event on its channel, and a compare above the period yields no events.

Other behaviour needs the bench's scenarios. These cover the full-cycle pulse widths over a sweep of periods and compare values, including both channel polarities, 0, P and P+1. They also cover the old-versus-new behaviour across a shadow write made in the middle of a cycle, the alternating toggle pattern, and the counter restart after a clear.

// File: rtl/updown_pwm_pkg.sv
package updown_pwm_pkg;

  // Two-bit action codes applied on a compare event.
  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_CLR  = 2'b01,
    ACT_SET  = 2'b10,
    ACT_TGL  = 2'b11
  } pwm_act_e;

  localparam int unsigned NUM_CHAN = 2;

  // New output level after an action is applied to the current level.
  function automatic logic f_apply(input logic [1:0] act, input logic cur);
    logic res;
    unique case (pwm_act_e'(act))
      ACT_NONE: res = cur;
      ACT_CLR:  res = 1'b0;
      ACT_SET:  res = 1'b1;
      default:  res = ~cur;
    endcase
    return res;
  endfunction

  // Output level after one clock, given the events seen on that clock.
  function automatic logic f_out_next(input logic ev_up, input logic ev_dn,
                                      input logic [1:0] act_up,
                                      input logic [1:0] act_dn,
                                      input logic cur);
    logic res;
    if (ev_up)      res = f_apply(act_up, cur);
    else if (ev_dn) res = f_apply(act_dn, cur);
    else            res = cur;
    return res;
  endfunction

endpackage

// File: rtl/updown_pwm_timebase.sv
module updown_pwm_timebase #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ctr_clr,
  input  logic         prd_wr,
  input  logic [W-1:0] prd_wdata,
  output logic [W-1:0] ctr,
  output logic         dir_down,
  output logic [W-1:0] prd_act,
  output logic         at_zero
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] ctr_q, ctr_n;
  logic         dir_q, dir_n;
  logic [W-1:0] prd_sh_q;
  logic [W-1:0] prd_act_q;
  logic         at_top;

  assign at_zero = (ctr_q == '0);
  // Peak reached while rising: turn around on this clock.
  assign at_top  = !dir_q && !at_zero && (ctr_q >= prd_act_q);

  always_comb begin
    if (ctr_clr) begin
      ctr_n = '0;
      dir_n = 1'b0;
    end else if (at_zero) begin
      // Period is being reloaded now; start rising with the incoming value.
      ctr_n = (prd_sh_q == '0) ? '0 : ONE;
      dir_n = 1'b0;
    end else if (at_top) begin
      ctr_n = ctr_q - ONE;
      dir_n = 1'b1;
    end else if (dir_q) begin
      ctr_n = ctr_q - ONE;
      dir_n = 1'b1;
    end else begin
      ctr_n = ctr_q + ONE;
      dir_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctr_q     <= '0;
      dir_q     <= 1'b0;
      prd_sh_q  <= '0;
      prd_act_q <= '0;
    end else begin
      ctr_q <= ctr_n;
      dir_q <= dir_n;
      if (prd_wr)  prd_sh_q  <= prd_wdata;
      if (at_zero) prd_act_q <= prd_sh_q;
    end
  end

  assign ctr      = ctr_q;
  assign dir_down = dir_q;
  assign prd_act  = prd_act_q;

endmodule

// File: rtl/updown_pwm_chan.sv
module updown_pwm_chan
  import updown_pwm_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         at_zero,
  input  logic         dir_down,
  input  logic [W-1:0] ctr,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_wdata,
  input  logic [1:0]   act_up,
  input  logic [1:0]   act_dn,
  output logic [W-1:0] cmp_act,
  output logic         evt_up,
  output logic         evt_dn,
  output logic         pwm
);

  logic [W-1:0] cmp_sh_q;
  logic [W-1:0] cmp_act_q;
  logic         pwm_q;
  logic         match;

  assign match  = (ctr == cmp_act_q);
  // Direction before any turn on this clock qualifies the match.
  assign evt_up = match && !dir_down;
  assign evt_dn = match &&  dir_down;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_sh_q  <= '0;
      cmp_act_q <= '0;
      pwm_q     <= 1'b0;
    end else begin
      if (cmp_wr)  cmp_sh_q  <= cmp_wdata;
      if (at_zero) cmp_act_q <= cmp_sh_q;
      pwm_q <= f_out_next(evt_up, evt_dn, act_up, act_dn, pwm_q);
    end
  end

  assign cmp_act = cmp_act_q;
  assign pwm     = pwm_q;

endmodule

// File: rtl/updown_pwm.sv
module updown_pwm
  import updown_pwm_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ctr_clr,
  input  logic         prd_wr,
  input  logic [W-1:0] prd_wdata,
  input  logic         cmpa_wr,
  input  logic [W-1:0] cmpa_wdata,
  input  logic         cmpb_wr,
  input  logic [W-1:0] cmpb_wdata,
  input  logic [1:0]   act_a_up,
  input  logic [1:0]   act_a_dn,
  input  logic [1:0]   act_b_up,
  input  logic [1:0]   act_b_dn,
  output logic [W-1:0] ctr,
  output logic         dir_down,
  output logic         out_a,
  output logic         out_b
);

  localparam int unsigned NCH = NUM_CHAN;

  // Named internal events, visible to the bound checker.
  logic [W-1:0] prd_act;
  logic         at_zero;
  logic [W-1:0] cmp_act_a, cmp_act_b;
  logic         evt_a, evt_b;

  logic         ch_wr    [NCH];
  logic [W-1:0] ch_wdata [NCH];
  logic [1:0]   ch_up    [NCH];
  logic [1:0]   ch_dn    [NCH];
  logic [W-1:0] ch_cmp   [NCH];
  logic         ch_evu   [NCH];
  logic         ch_evd   [NCH];
  logic         ch_pwm   [NCH];

  assign ch_wr[0]    = cmpa_wr;
  assign ch_wr[1]    = cmpb_wr;
  assign ch_wdata[0] = cmpa_wdata;
  assign ch_wdata[1] = cmpb_wdata;
  assign ch_up[0]    = act_a_up;
  assign ch_up[1]    = act_b_up;
  assign ch_dn[0]    = act_a_dn;
  assign ch_dn[1]    = act_b_dn;

  updown_pwm_timebase #(.W(W)) u_tb (
    .clk       (clk),
    .rst       (rst),
    .ctr_clr   (ctr_clr),
    .prd_wr    (prd_wr),
    .prd_wdata (prd_wdata),
    .ctr       (ctr),
    .dir_down  (dir_down),
    .prd_act   (prd_act),
    .at_zero   (at_zero)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    updown_pwm_chan #(.W(W)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .at_zero   (at_zero),
      .dir_down  (dir_down),
      .ctr       (ctr),
      .cmp_wr    (ch_wr[g]),
      .cmp_wdata (ch_wdata[g]),
      .act_up    (ch_up[g]),
      .act_dn    (ch_dn[g]),
      .cmp_act   (ch_cmp[g]),
      .evt_up    (ch_evu[g]),
      .evt_dn    (ch_evd[g]),
      .pwm       (ch_pwm[g])
    );
  end

  assign cmp_act_a = ch_cmp[0];
  assign cmp_act_b = ch_cmp[1];
  assign evt_a     = ch_evu[0] | ch_evd[0];
  assign evt_b     = ch_evu[1] | ch_evd[1];
  assign out_a     = ch_pwm[0];
  assign out_b     = ch_pwm[1];

endmodule

// File: rtl/updown_pwm_chk.sv
module updown_pwm_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         ctr_clr,
  input logic [W-1:0] ctr,
  input logic         dir_down,
  input logic         at_zero,
  input logic [W-1:0] prd_act,
  input logic [W-1:0] cmp_act_a,
  input logic [W-1:0] cmp_act_b,
  input logic         evt_a,
  input logic         evt_b,
  input logic         out_a,
  input logic         out_b
);

  AST_CTR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    ctr <= prd_act); // R1

  AST_CTR_RISES: assert property (@(posedge clk) disable iff (rst)
    (!dir_down && !at_zero && ctr != prd_act && !ctr_clr) |=> (ctr == $past(ctr) + 1'b1)); // R1

  AST_TURN_AT_PEAK: assert property (@(posedge clk) disable iff (rst)
    (!dir_down && !at_zero && ctr == prd_act && !ctr_clr) |=> dir_down); // R2

  AST_TURN_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    at_zero |=> !dir_down); // R2

  AST_CMPA_HELD: assert property (@(posedge clk) disable iff (rst)
    !at_zero |=> $stable(cmp_act_a)); // R4

  AST_CMPB_HELD: assert property (@(posedge clk) disable iff (rst)
    !at_zero |=> $stable(cmp_act_b)); // R4

  AST_PRD_HELD: assert property (@(posedge clk) disable iff (rst)
    !at_zero |=> $stable(prd_act)); // R5

  AST_CLR_RESTART: assert property (@(posedge clk) disable iff (rst)
    ctr_clr |=> (ctr == '0 && !dir_down)); // R6

  AST_OUTA_QUIET: assert property (@(posedge clk) disable iff (rst)
    !evt_a |=> $stable(out_a)); // R7

  AST_OUTB_QUIET: assert property (@(posedge clk) disable iff (rst)
    !evt_b |=> $stable(out_b)); // R7

  AST_A_ABOVE_PRD: assert property (@(posedge clk) disable iff (rst)
    (cmp_act_a > prd_act) |-> !evt_a); // R8

  AST_B_ABOVE_PRD: assert property (@(posedge clk) disable iff (rst)
    (cmp_act_b > prd_act) |-> !evt_b); // R8

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (ctr == '0 && !dir_down && !out_a && !out_b && prd_act == '0)); // R9

endmodule

bind updown_pwm updown_pwm_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ctr_clr   (ctr_clr),
  .ctr       (ctr),
  .dir_down  (dir_down),
  .at_zero   (at_zero),
  .prd_act   (prd_act),
  .cmp_act_a (cmp_act_a),
  .cmp_act_b (cmp_act_b),
  .evt_a     (evt_a),
  .evt_b     (evt_b),
  .out_a     (out_a),
  .out_b     (out_b)
);

// File: tb/test_updown_pwm.sv
module test_updown_pwm;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ctr_clr = 1'b0;
  logic         prd_wr = 1'b0;
  logic [W-1:0] prd_wdata = '0;
  logic         cmpa_wr = 1'b0;
  logic [W-1:0] cmpa_wdata = '0;
  logic         cmpb_wr = 1'b0;
  logic [W-1:0] cmpb_wdata = '0;
  logic [1:0]   act_a_up = 2'b00;
  logic [1:0]   act_a_dn = 2'b00;
  logic [1:0]   act_b_up = 2'b00;
  logic [1:0]   act_b_dn = 2'b00;
  logic [W-1:0] ctr;
  logic         dir_down;
  logic         out_a;
  logic         out_b;

  int n_chk = 0;
  int n_fail = 0;

  updown_pwm #(.W(W)) i_updown_pwm (
    .clk(clk), .rst(rst), .ctr_clr(ctr_clr),
    .prd_wr(prd_wr), .prd_wdata(prd_wdata),
    .cmpa_wr(cmpa_wr), .cmpa_wdata(cmpa_wdata),
    .cmpb_wr(cmpb_wr), .cmpb_wdata(cmpb_wdata),
    .act_a_up(act_a_up), .act_a_dn(act_a_dn),
    .act_b_up(act_b_up), .act_b_dn(act_b_dn),
    .ctr(ctr), .dir_down(dir_down), .out_a(out_a), .out_b(out_b)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Expected high clocks per cycle, set on rise / clear on fall (R3, R8).
  function automatic int exp_hi_a(input int p, input int c);
    if (c >= 1 && c < p) return 2 * (p - c);
    if (c == p) return 2 * p;
    return 0;
  endfunction

  // Expected high clocks per cycle, clear on rise / set on fall (R7).
  function automatic int exp_hi_b(input int p, input int c);
    if (c >= 1 && c < p) return 2 * c;
    if (c == 0) return 2 * p;
    return 0;
  endfunction

  // Reset, load shadows with actions idle, then arm the actions once counting.
  task automatic setup(input int p, input int ca, input int cb,
                       input logic [1:0] au, input logic [1:0] ad,
                       input logic [1:0] bu, input logic [1:0] bd);
    @(negedge clk);
    rst = 1'b1;
    act_a_up = 2'b00; act_a_dn = 2'b00; act_b_up = 2'b00; act_b_dn = 2'b00;
    @(negedge clk);
    rst = 1'b0;
    prd_wr = 1'b1;  prd_wdata = W'(p);
    cmpa_wr = 1'b1; cmpa_wdata = W'(ca);
    cmpb_wr = 1'b1; cmpb_wdata = W'(cb);
    @(negedge clk);
    prd_wr = 1'b0; cmpa_wr = 1'b0; cmpb_wr = 1'b0;
    @(negedge clk);
    act_a_up = au; act_a_dn = ad; act_b_up = bu; act_b_dn = bd;
  endtask

  // One full cycle aligned to a zero point. wk: 1 writes compare A, 2 writes period.
  task automatic measure(input int p, input int wk, input int wv,
                         output int ha, output int hb, output bit shape_ok, output bit a0);
    int g;
    int ec;
    bit ed;
    ha = 0; hb = 0; shape_ok = 1'b1; a0 = 1'b0;
    @(negedge clk);
    g = 0;
    while (ctr != '0 && g < 5000) begin
      @(negedge clk);
      g++;
    end
    for (int i = 0; i < 2 * p; i++) begin
      if (i > 0) @(negedge clk);
      if (i == 0) a0 = out_a;
      if (out_a) ha++;
      if (out_b) hb++;
      ec = (i <= p) ? i : 2 * p - i;
      ed = (i == 0) || (i > p);
      if (int'(ctr) != ec || dir_down != ed) shape_ok = 1'b0;
      if (i == 2 && wk == 1) begin cmpa_wr = 1'b1; cmpa_wdata = W'(wv); end
      if (i == 2 && wk == 2) begin prd_wr = 1'b1; prd_wdata = W'(wv); end
      if (i == 3) begin cmpa_wr = 1'b0; prd_wr = 1'b0; end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    int ha, hb;
    bit sh, a0, prev;
    // R9: state right after reset.
    repeat (2) @(negedge clk);
    check(ctr == '0 && !dir_down && !out_a && !out_b, "R9 reset state", int'(ctr), 0);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(ctr == '0, "R9 zero period holds counter", int'(ctr), 0);

    // R1 R2 R3 R7 R8 R10: sweep of period and compare values.
    for (int p = 2; p <= 6; p++) begin
      for (int c = 0; c <= p + 1; c++) begin
        setup(p, c, c, 2'b10, 2'b01, 2'b01, 2'b10);
        measure(p, 0, 0, ha, hb, sh, a0);
        measure(p, 0, 0, ha, hb, sh, a0);
        measure(p, 0, 0, ha, hb, sh, a0);
        check(sh, "R1 R2 triangle shape", p, c);
        check(ha == exp_hi_a(p, c), (c > p || c == 0) ? "R8 A high clocks" : "R3 A high clocks",
              ha, exp_hi_a(p, c));
        check(hb == exp_hi_b(p, c), "R7 R10 B inverse high clocks", hb, exp_hi_b(p, c));
      end
    end

    // R7: toggle on rise only alternates the level each cycle; idle B stays low.
    setup(4, 2, 1, 2'b11, 2'b00, 2'b00, 2'b00);
    measure(4, 0, 0, ha, hb, sh, prev);
    for (int k = 0; k < 3; k++) begin
      measure(4, 0, 0, ha, hb, sh, a0);
      check(a0 != prev, "R7 toggle alternates", int'(a0), int'(!prev));
      check(hb == 0, "R7 no-action output idle", hb, 0);
      prev = a0;
    end

    // R4: compare write mid-cycle applies from the next cycle.
    setup(5, 2, 9, 2'b10, 2'b01, 2'b10, 2'b01);
    measure(5, 0, 0, ha, hb, sh, a0);
    measure(5, 0, 0, ha, hb, sh, a0);
    measure(5, 1, 4, ha, hb, sh, a0);
    check(ha == 6, "R4 old compare kept this cycle", ha, 6);
    measure(5, 0, 0, ha, hb, sh, a0);
    check(ha == 2, "R4 new compare next cycle", ha, 2);

    // R5: period write mid-cycle applies from the next cycle.
    setup(4, 2, 9, 2'b10, 2'b01, 2'b10, 2'b01);
    measure(4, 0, 0, ha, hb, sh, a0);
    measure(4, 0, 0, ha, hb, sh, a0);
    measure(4, 2, 6, ha, hb, sh, a0);
    check(sh && ha == 4, "R5 old period kept this cycle", ha, 4);
    measure(6, 0, 0, ha, hb, sh, a0);
    check(sh && ha == 8, "R5 new period next cycle", ha, 8);

    // R6: clear strobe restarts the count upward.
    setup(5, 2, 9, 2'b10, 2'b01, 2'b10, 2'b01);
    measure(5, 0, 0, ha, hb, sh, a0);
    while (ctr != W'(3)) @(negedge clk);
    ctr_clr = 1'b1;
    @(negedge clk);
    ctr_clr = 1'b0;
    check(ctr == '0 && !dir_down, "R6 clear to zero rising", int'(ctr), 0);
    @(negedge clk);
    check(ctr == W'(1), "R6 count resumes", int'(ctr), 1);

    // R9: reset in the middle of a high pulse.
    setup(4, 1, 9, 2'b10, 2'b01, 2'b10, 2'b01);
    measure(4, 0, 0, ha, hb, sh, a0);
    while (!out_a) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(ctr == '0 && !dir_down && !out_a && !out_b, "R9 reset mid-pulse", int'(out_a), 0);
    @(negedge clk);
    check(ctr == '0, "R9 shadows cleared", int'(ctr), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule